// File: doc/BRIEF.md
# Bus-Mastering DMA Engine

This block moves a programmed run of 8-bit words between an I/O device and memory without the processor touching each word. While idle it behaves as a bus slave: the processor writes a start address and a word count through a small register port. When the device then raises its request, the engine asks the processor for the bus with `hold` and waits for `hold_ack`. Only after that grant does it acknowledge the device. It then moves one word at a time, always reading the source into an internal buffer before writing the buffer to the destination. Each word advances the address by one and lowers the count by one. When the count reaches zero the engine pulses terminal count, gives the bus back and raises a sticky interrupt.

The controller steps through five states: idle, granted, device-status check, strobe phase and terminal check. The processor keeps priority throughout. Whenever `hold_ack` is low, no memory or device strobe is issued and the engine waits in its current state, then resumes with no word lost or repeated. The device picks the direction of each word with `dev_dir`. On the device side, word movement follows valid/ready rules. Device to memory: `dev_ready` is the device's valid, and a word on `dev_wdata` is consumed in the cycle `dev_pop` is high. Memory to device: `dev_ready` is the device's ready, and the buffered word on `dev_rdata` is delivered in the cycle `dev_push` is high. The device applies back-pressure by holding `dev_ready` low, and the processor does so by dropping `hold_ack`. Memory reads are combinational: `mem_rdata` is valid in the same cycle as `mem_re`.

Top module: `busmaster_dma`

## Requirements
- R1: After reset, `hold`, `dma_ack`, `tc`, `irq`, `mem_re`, `mem_we`, `dev_pop` and `dev_push` are low, and both registers read back as zero.
- R2: Register access uses these addresses: a write to address 0x1FF loads the start address, and a write to 0x2FF loads the count. `cfg_rdata` returns the current value of the addressed register, or zero for any other address.
- R3: A request is served only if the count has been written since the last terminal count. `dma_ack` rises only in the cycle after one in which `hold_ack` was high, and it is only ever high while `hold` is high.
- R4: With `dev_dir`=1 (device to memory), each word taken on `dev_pop` is written to memory at the current address with `mem_we`. The word after the last address of the run is left unchanged.
- R5: With `dev_dir`=0 (memory to device), each word read with `mem_re` is delivered on `dev_rdata` with `dev_push`, in address order. Memory is not written.
- R6: The address increments by one per word and wraps modulo 256. The count decrements by one per word. After a run of N words from start address B, the address register reads (B+N) mod 256 and the count reads 0.
- R7: `mem_re`, `mem_we`, `dev_pop` and `dev_push` are asserted only while both `hold` and `hold_ack` are high. If the bus is taken back in the middle of a run, exactly N words still move.
- R8: No source word is taken (`mem_re` or `dev_pop`) while `dev_ready` is low.
- R9: When the count reaches zero, `tc` is high for one cycle. In the next cycle `hold` and `dma_ack` are low and `irq` is high.
- R10: If a request arrives with the count programmed as zero, terminal count occurs at once: `hold` is never raised and no word moves.
- R11: `irq` stays high until the processor reads or writes the count address (0x2FF).
- R12: After terminal count, a request that is still held gets no service (`hold` stays low) until the count is written again.
- R13: Register writes made while a run is in progress (any state other than idle) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (a read of the count clears `irq`) |
| cfg_addr | input | 12 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the addressed register |
| dma_req | input | 1 | Device service request |
| dma_ack | output | 1 | Acknowledge to the device, high while the engine owns the run |
| dev_ready | input | 1 | Device status: valid (device to memory) or ready (memory to device) |
| dev_dir | input | 1 | Word direction: 1 device to memory, 0 memory to device |
| dev_wdata | input | 8 | Word from the device |
| dev_pop | output | 1 | Device word consumed this cycle |
| dev_rdata | output | 8 | Buffered word to the device |
| dev_push | output | 1 | `dev_rdata` delivered this cycle |
| hold | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | 8 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle as `mem_re` |
| tc | output | 1 | Terminal-count pulse |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions assume the processor raises `hold_ack` only while `hold` is high, and that the device holds `dev_dir` steady while `dev_ready` qualifies a word. The bench drives `hold_ack` and `dev_ready` from a shift-register pattern on the falling edge. It derives `hold_ack` as `hold` gated by that pattern, so a grant never appears without a request. It changes `dev_dir` only between runs. Register writes reach the engine only through the idle-state path, apart from the deliberate mid-run writes that check R13.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GRANT = 3'd1,
    ST_CHECK = 3'd2,
    ST_STRB  = 3'd3,
    ST_TCCHK = 3'd4
  } dma_state_e;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int REG_W  = 8,
  parameter int CFG_AW = 12,
  parameter logic [CFG_AW-1:0] BASE_ADDR  = 'h1FF,
  parameter logic [CFG_AW-1:0] COUNT_ADDR = 'h2FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              wr_ok,
  input  logic              step,
  input  logic              terminal,
  output logic [REG_W-1:0]  addr_q,
  output logic [REG_W-1:0]  cnt_q,
  output logic              armed_q,
  output logic              irq_q
);
  logic hit_base, hit_cnt, wr_base, wr_cnt, cnt_touch;

  assign hit_base  = (cfg_addr == BASE_ADDR);
  assign hit_cnt   = (cfg_addr == COUNT_ADDR);
  assign wr_base   = cfg_we && wr_ok && hit_base;
  assign wr_cnt    = cfg_we && wr_ok && hit_cnt;
  assign cnt_touch = wr_cnt || (cfg_re && hit_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_base)   addr_q <= cfg_wdata;
      else if (step) addr_q <= addr_q + 1'b1;
      if (wr_cnt)    cnt_q <= cfg_wdata;
      else if (step) cnt_q <= cnt_q - 1'b1;
      if (terminal)    armed_q <= 1'b0;
      else if (wr_cnt) armed_q <= 1'b1;
      if (terminal)       irq_q <= 1'b1;
      else if (cnt_touch) irq_q <= 1'b0;
    end
  end

  always_comb begin
    if (hit_base)     cfg_rdata = addr_q;
    else if (hit_cnt) cfg_rdata = cnt_q;
    else              cfg_rdata = '0;
  end
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic armed,
  input  logic cnt_zero,
  input  logic hold_ack,
  input  logic dev_ready,
  output logic hold,
  output logic dma_ack,
  output logic src_fire,
  output logic dst_fire,
  output logic terminal,
  output logic idle
);
  dma_state_e state_q, state_d;

  assign src_fire = (state_q == ST_CHECK) && hold_ack && dev_ready;
  assign dst_fire = (state_q == ST_STRB) && hold_ack;
  assign terminal = (state_q == ST_TCCHK) && cnt_zero;
  assign idle     = (state_q == ST_IDLE);
  assign dma_ack  = (state_q == ST_CHECK) || (state_q == ST_STRB) ||
                    ((state_q == ST_TCCHK) && !cnt_zero);
  assign hold     = (state_q == ST_GRANT) || dma_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req && armed) state_d = cnt_zero ? ST_TCCHK : ST_GRANT;
      ST_GRANT: if (hold_ack) state_d = ST_CHECK;
      ST_CHECK: if (src_fire) state_d = ST_STRB;
      ST_STRB:  if (dst_fire) state_d = ST_TCCHK;
      ST_TCCHK: state_d = cnt_zero ? ST_IDLE : ST_CHECK;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/dma_word_path.sv
module dma_word_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_fire,
  input  logic              dst_fire,
  input  logic              dev_dir,
  input  logic [DATA_W-1:0] dev_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] buf_word,
  output logic              mem_re,
  output logic              mem_we,
  output logic              dev_pop,
  output logic              dev_push
);
  logic dir_q;

  assign mem_re   = src_fire && !dev_dir;
  assign dev_pop  = src_fire && dev_dir;
  assign mem_we   = dst_fire && dir_q;
  assign dev_push = dst_fire && !dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_word <= '0;
      dir_q    <= 1'b0;
    end else if (src_fire) begin
      dir_q    <= dev_dir;
      buf_word <= dev_dir ? dev_wdata : mem_rdata;
    end
  end
endmodule

// File: rtl/busmaster_dma.sv
module busmaster_dma #(
  parameter int REG_W  = 8,
  parameter int DATA_W = 8,
  parameter int CFG_AW = 12,
  parameter logic [CFG_AW-1:0] BASE_ADDR  = 'h1FF,
  parameter logic [CFG_AW-1:0] COUNT_ADDR = 'h2FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              dma_req,
  output logic              dma_ack,
  input  logic              dev_ready,
  input  logic              dev_dir,
  input  logic [DATA_W-1:0] dev_wdata,
  output logic              dev_pop,
  output logic [DATA_W-1:0] dev_rdata,
  output logic              dev_push,
  output logic              hold,
  input  logic              hold_ack,
  output logic [REG_W-1:0]  mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tc,
  output logic              irq
);
  logic [REG_W-1:0]  addr_q, cnt_q;
  logic [DATA_W-1:0] buf_word;
  logic armed, src_fire, dst_fire, terminal, idle;

  dma_cfg_regs #(
    .REG_W(REG_W), .CFG_AW(CFG_AW),
    .BASE_ADDR(BASE_ADDR), .COUNT_ADDR(COUNT_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wr_ok(idle), .step(dst_fire), .terminal(terminal),
    .addr_q(addr_q), .cnt_q(cnt_q), .armed_q(armed), .irq_q(irq)
  );

  dma_sequencer seq_i (
    .clk(clk), .rst_n(rst_n),
    .req(dma_req), .armed(armed), .cnt_zero(cnt_q == '0),
    .hold_ack(hold_ack), .dev_ready(dev_ready),
    .hold(hold), .dma_ack(dma_ack),
    .src_fire(src_fire), .dst_fire(dst_fire),
    .terminal(terminal), .idle(idle)
  );

  dma_word_path #(.DATA_W(DATA_W)) path_i (
    .clk(clk), .rst_n(rst_n),
    .src_fire(src_fire), .dst_fire(dst_fire),
    .dev_dir(dev_dir), .dev_wdata(dev_wdata), .mem_rdata(mem_rdata),
    .buf_word(buf_word),
    .mem_re(mem_re), .mem_we(mem_we), .dev_pop(dev_pop), .dev_push(dev_push)
  );

  assign mem_addr  = addr_q;
  assign mem_wdata = buf_word;
  assign dev_rdata = buf_word;
  assign tc        = terminal;
endmodule

// File: rtl/busmaster_dma_chk.sv
module busmaster_dma_chk #(
  parameter int CFG_AW = 12,
  parameter logic [CFG_AW-1:0] COUNT_ADDR = 'h2FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              hold_ack,
  input logic              dma_ack,
  input logic              tc,
  input logic              irq,
  input logic              mem_re,
  input logic              mem_we,
  input logic              dev_pop,
  input logic              dev_push,
  input logic              cfg_we,
  input logic              cfg_re,
  input logic [CFG_AW-1:0] cfg_addr
);
  // R7
  bus_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we || dev_pop || dev_push) |-> (hold && hold_ack));
  // R3
  ack_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_ack) |-> $past(hold_ack));
  // R3
  ack_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |-> hold);
  // R9
  tc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (!hold && !dma_ack && irq));
  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !((cfg_we || cfg_re) && cfg_addr == COUNT_ADDR)) |=> irq);
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we, dev_pop, dev_push}));
endmodule

bind busmaster_dma busmaster_dma_chk #(
  .CFG_AW(CFG_AW), .COUNT_ADDR(COUNT_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hold(hold), .hold_ack(hold_ack),
  .dma_ack(dma_ack), .tc(tc), .irq(irq),
  .mem_re(mem_re), .mem_we(mem_we), .dev_pop(dev_pop), .dev_push(dev_push),
  .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr)
);

// File: tb/busmaster_dma_tb_top.sv
module busmaster_dma_tb_top;
  localparam logic [11:0] A_BASE = 12'h1FF;
  localparam logic [11:0] A_CNT  = 12'h2FF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_re = 0;
  logic [11:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic dma_req = 0, dma_ack, dev_ready = 0, dev_dir = 0;
  logic [7:0] dev_wdata, dev_rdata, mem_addr, mem_wdata, mem_rdata;
  logic dev_pop, dev_push, hold, hold_ack = 0, mem_re, mem_we, tc, irq;

  busmaster_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dma_req(dma_req), .dma_ack(dma_ack), .dev_ready(dev_ready),
    .dev_dir(dev_dir), .dev_wdata(dev_wdata), .dev_pop(dev_pop),
    .dev_rdata(dev_rdata), .dev_push(dev_push), .hold(hold),
    .hold_ack(hold_ack), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tc(tc), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [256];
  logic [7:0] rx [256];
  logic [7:0] seed = '0;
  int k = 0, pushes = 0, tcs = 0, viol = 0, rdy_viol = 0, early = 0, hcyc = 0;
  logic granted = 0, stall = 0;
  logic [15:0] lfsr = 16'hACE1;

  assign mem_rdata = mem[mem_addr];
  assign dev_wdata = 8'(k * 13) + seed;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (dev_pop) k <= k + 1;
    if (dev_push) begin rx[pushes[7:0]] <= dev_rdata; pushes <= pushes + 1; end
    if (tc) tcs <= tcs + 1;
    if (hold) hcyc <= hcyc + 1;
    if (hold && hold_ack) granted <= 1'b1;
    if (dma_ack && !granted) early <= early + 1;
    if ((mem_re || mem_we || dev_pop || dev_push) && !(hold && hold_ack)) viol <= viol + 1;
    if ((mem_re || dev_pop) && !dev_ready) rdy_viol <= rdy_viol + 1;
  end

  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    hold_ack  <= hold && (!stall || lfsr[0] || lfsr[3]);
    dev_ready <= !stall || lfsr[5] || lfsr[9];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_re = 1;
    #2 d = cfg_rdata;
    @(negedge clk); cfg_re = 0;
  endtask

  task automatic run_xfer(input logic [7:0] b, input int n, input bit dir,
                          input bit stl, input bit midwr);
    logic [7:0] img [256];
    logic [7:0] rd;
    int t, bad, h0;
    for (int i = 0; i < 256; i++) begin img[i] = 8'(i * 29 + 7); mem[i] = img[i]; end
    seed = b ^ 8'h5A; stall = stl; dev_dir = dir;
    cfg_write(A_BASE, b);
    cfg_write(A_CNT, n[7:0]);
    @(negedge clk);
    k = 0; pushes = 0; tcs = 0; viol = 0; rdy_viol = 0; early = 0; hcyc = 0; granted = 0;
    dma_req = 1;
    if (midwr) begin
      t = 0;
      while (!dma_ack && t < 200) begin @(negedge clk); t++; end
      cfg_write(A_CNT, 8'h77);
    end
    t = 0;
    while (!irq && t < 3000) begin @(negedge clk); t++; end
    chk(irq == 1'b1, "R9 irq raised at end of run", irq, 1);
    h0 = hcyc;
    repeat (12) @(negedge clk);
    chk(hcyc == h0, "R12 no hold after terminal while request held", hcyc - h0, 0);
    chk(irq == 1'b1, "R11 irq stays set", irq, 1);
    dma_req = 0;
    chk(tcs == 1, "R9 single tc pulse", tcs, 1);
    chk(viol == 0, "R7 strobes only while bus owned", viol, 0);
    chk(rdy_viol == 0, "R8 no source take while not ready", rdy_viol, 0);
    chk(early == 0, "R3 dma_ack only after grant", early, 0);
    if (n == 0) chk(hcyc == 0, "R10 zero count never holds", hcyc, 0);
    bad = 0;
    if (dir) begin
      chk(k == n, "R4 words taken from device", k, n);
      for (int i = 0; i < n; i++)
        if (mem[8'(b + i)] !== 8'(i * 13) + seed) bad++;
      chk(bad == 0, "R4 memory holds device words", bad, 0);
      chk(mem[8'(b + n)] === img[8'(b + n)], "R4 word past run untouched",
          mem[8'(b + n)], img[8'(b + n)]);
    end else begin
      chk(pushes == n, "R5 words pushed to device", pushes, n);
      for (int i = 0; i < n; i++)
        if (rx[i] !== img[8'(b + i)]) bad++;
      for (int i = 0; i < 256; i++)
        if (mem[i] !== img[i]) bad++;
      chk(bad == 0, "R5 device got memory words, memory unchanged", bad, 0);
    end
    cfg_read(A_BASE, rd);
    chk(rd == 8'(b + n), "R6 address register after run", rd, 8'(b + n));
    cfg_read(A_CNT, rd);
    chk(rd == 8'h00, midwr ? "R13 mid-run count write ignored" : "R6 count reads zero", rd, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R11 count read clears irq", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({hold, dma_ack, tc, irq, mem_re, mem_we, dev_pop, dev_push} == 8'h00,
        "R1 outputs low after reset",
        {hold, dma_ack, tc, irq, mem_re, mem_we, dev_pop, dev_push}, 0);
    cfg_read(A_BASE, rd); chk(rd == 0, "R1 address register zero", rd, 0);
    cfg_read(A_CNT, rd);  chk(rd == 0, "R1 count register zero", rd, 0);
    cfg_write(A_BASE, 8'hA5); cfg_read(A_BASE, rd);
    chk(rd == 8'hA5, "R2 address register write at 0x1FF", rd, 8'hA5);
    cfg_write(A_CNT, 8'h3C); cfg_read(A_CNT, rd);
    chk(rd == 8'h3C, "R2 count register write at 0x2FF", rd, 8'h3C);
    cfg_read(12'h0FF, rd); chk(rd == 0, "R2 unmapped address reads zero", rd, 0);
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int ni = 0; ni < 4; ni++) begin
          int nn;
          nn = (ni == 3) ? 5 : ni;
          run_xfer(8'(ni * 61 + d * 17 + s * 100), nn, d[0], s[0], 1'b0);
        end
    run_xfer(8'hFD, 6, 1'b1, 1'b1, 1'b0);
    run_xfer(8'hFE, 4, 1'b0, 1'b1, 1'b0);
    run_xfer(8'h40, 4, 1'b0, 1'b0, 1'b1);
    run_xfer(8'h80, 3, 1'b1, 1'b1, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule